// File: doc/BRIEF.md
# Warp-Aware Shortest-Queue Bank Scheduler

This block picks the next memory request for one DRAM bank. Requests are not kept one by one. Each warp slot (a core index paired with a warp index) holds two small counters, one for reads and one for writes, and a row tag. The row tag is the row of the most recent request enqueued to that slot, and every pending request of the slot is taken to target that row. A slot is a row hit when its tag equals the bank's open row.

Picking a request takes two steps. The first step favours the core least able to hide latency. That is the core with the fewest assigned warps, a count that software loads per core. The second step works inside that core. It finds the shortest hit queue and the shortest miss queue, and weighs them with a programmable factor `k`. This trades draining a short queue, which frees a warp sooner, against keeping the open row busy.

Once a hit queue is granted it stays chosen until it has no hits left. A write-handling mode selects one of two behaviours:
- writes wait until every read in the bank is served, or
- writes count in their warp's queue the same way reads do.

Top module: `shq_bank_sched`

## Requirements
- R1: After reset, and whenever `bank_ready` is low or no request is pending, `gnt_valid` is 0.
- R2: With no sticky queue, the grant comes from the core that has eligible requests and the smallest assigned-warp count. Ties go to the lower core index. Counts reset to 0 and change only through `wcnt_load`.
- R3: Each warp slot counts pending reads and writes. A grant takes one request off at the same clock edge it is issued, so the next grant already sees it gone. An enqueue and a grant of the same kind to the same slot in one cycle leave that count unchanged.
- R4: A slot is a hit when its queue length is non-zero and its row tag (row of its latest enqueue) equals `open_row`. Hs is the shortest hit queue in the chosen core and Ms the shortest miss queue. Ties go to the lower warp index.
- R5: When both Hs and Ms exist, Ms is granted exactly when len(Hs)·16 > k·len(Ms). Otherwise Hs is granted. `k` is an 8-bit unsigned value with 4 fraction bits, resets to 144 (9.0) and is loaded through `k_load`.
- R6: When the chosen core has only miss queues, Ms is granted. When it has only hit queues, Hs is granted.
- R7: After a hit grant, the same slot keeps being granted while it is still a hit, even if another core or queue would now win. When it stops being a hit, selection runs again.
- R8: With `write_equal` = 0, a slot's queue length is its read count while any read is pending in the bank, and its write count otherwise. No write is granted while a read is pending.
- R9: With `write_equal` = 1, a slot's queue length is reads plus writes. Within a slot, reads are granted before writes.
- R10: `gnt_valid`, `gnt_core`, `gnt_warp`, `gnt_hit` (1 = row hit) and `gnt_write` (1 = write) are valid in the same cycle that `bank_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue one request this cycle |
| enq_core | input | CORE_W | Issuing core of the request |
| enq_warp | input | WARP_W | Issuing warp within the core |
| enq_row | input | ROW_W | Row targeted by the request |
| enq_write | input | 1 | 1 = write, 0 = read |
| open_row | input | ROW_W | Row currently open in the bank |
| wcnt_load | input | 1 | Load an assigned-warp count |
| wcnt_core | input | CORE_W | Core whose count is loaded |
| wcnt_value | input | WCNT_W | New assigned-warp count |
| k_load | input | 1 | Load the weighting factor |
| k_value | input | K_W | New weighting factor, 4 fraction bits |
| write_equal | input | 1 | 0 = writes after reads, 1 = writes queued like reads |
| bank_ready | input | 1 | Bank can accept a request this cycle |
| gnt_valid | output | 1 | A request is granted this cycle |
| gnt_core | output | CORE_W | Granted core |
| gnt_warp | output | WARP_W | Granted warp within the core |
| gnt_hit | output | 1 | Granted queue hits the open row |
| gnt_write | output | 1 | Granted request is a write |

## Verification
The grant fields depend only on registered state, `open_row` and `bank_ready`, so they are due in the same cycle `bank_ready` rises. The bench drives `bank_ready` on the falling edge and compares the grant fields one nanosecond later, before the next rising edge. Enqueues, count loads, `k` loads, counter decrements and the sticky choice all take effect at the next rising edge. For that reason each follow-up grant or drain count is started only on a later falling edge. The `k` comparison is swept across four factors and all Hs/Ms lengths from 1 to 5, and core choice is swept across all pairs of counts from 0 to 3. In every case the expected winner is worked out arithmetically in the bench.

// File: rtl/shq_pkg.sv
package shq_pkg;

  // Write-handling policy of the bank scheduler
  typedef enum logic {
    WR_DEFER = 1'b0,  // writes wait for all reads in the bank
    WR_EQUAL = 1'b1   // writes are queued with their warp like reads
  } wr_mode_e;

endpackage

// File: rtl/shq_counters.sv
// Per-warp pending read/write counters and row tags.
module shq_counters #(
  parameter int N_WARPS = 8,
  parameter int CNT_W   = 5,
  parameter int ROW_W   = 8,
  parameter int WIDX_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            enq_valid,
  input  logic [WIDX_W-1:0]               enq_idx,
  input  logic [ROW_W-1:0]                enq_row,
  input  logic                            enq_write,
  input  logic                            dec_valid,
  input  logic [WIDX_W-1:0]               dec_idx,
  input  logic                            dec_write,
  output logic [N_WARPS-1:0][CNT_W-1:0]   rd_cnt,
  output logic [N_WARPS-1:0][CNT_W-1:0]   wr_cnt,
  output logic [N_WARPS-1:0][ROW_W-1:0]   row_tag
);

  for (genvar w = 0; w < N_WARPS; w++) begin : g_warp
    logic             enq_here;
    logic             dec_here;
    logic [CNT_W-1:0] rd_q, rd_d;
    logic [CNT_W-1:0] wr_q, wr_d;
    logic [ROW_W-1:0] tag_q;

    always_comb begin
      enq_here = enq_valid && (enq_idx == WIDX_W'(w));
      dec_here = dec_valid && (dec_idx == WIDX_W'(w));
      rd_d = rd_q;
      wr_d = wr_q;
      if (enq_here && !enq_write) rd_d = rd_d + CNT_W'(1);
      if (enq_here &&  enq_write) wr_d = wr_d + CNT_W'(1);
      if (dec_here && !dec_write) rd_d = rd_d - CNT_W'(1);
      if (dec_here &&  dec_write) wr_d = wr_d - CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q  <= '0;
        wr_q  <= '0;
        tag_q <= '0;
      end else begin
        rd_q <= rd_d;
        wr_q <= wr_d;
        if (enq_here) tag_q <= enq_row;
      end
    end

    assign rd_cnt[w]  = rd_q;
    assign wr_cnt[w]  = wr_q;
    assign row_tag[w] = tag_q;
  end

endmodule

// File: rtl/shq_core_pick.sv
// Picks the busy core with the smallest assigned-warp count (lowest index on ties).
module shq_core_pick #(
  parameter int N_CORES = 2,
  parameter int WCNT_W  = 8,
  parameter int CORE_W  = 1
) (
  input  logic [N_CORES-1:0]             core_busy,
  input  logic [N_CORES-1:0][WCNT_W-1:0] wcnt,
  output logic                           core_any,
  output logic [CORE_W-1:0]              core_sel
);

  logic [WCNT_W-1:0] best;

  always_comb begin
    core_any = 1'b0;
    core_sel = '0;
    best     = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (core_busy[c] && (!core_any || (wcnt[c] < best))) begin
        core_any = 1'b1;
        best     = wcnt[c];
        core_sel = CORE_W'(c);
      end
    end
  end

endmodule

// File: rtl/shq_queue_pick.sv
// Within one core: shortest hit queue against k times the shortest miss queue.
module shq_queue_pick #(
  parameter int WPC    = 4,
  parameter int LEN_W  = 6,
  parameter int K_W    = 8,
  parameter int K_FRAC = 4,
  parameter int WARP_W = 2
) (
  input  logic [WPC-1:0][LEN_W-1:0] len,
  input  logic [WPC-1:0]            hit,
  input  logic [K_W-1:0]            k,
  output logic                      pick_valid,
  output logic [WARP_W-1:0]         pick_warp,
  output logic                      pick_hit
);

  localparam int PROD_W = LEN_W + K_W;

  logic              hs_v, ms_v;
  logic [LEN_W-1:0]  hs_len, ms_len;
  logic [WARP_W-1:0] hs_w, ms_w;
  logic [PROD_W-1:0] hs_scaled, ms_scaled;
  logic              choose_ms;

  always_comb begin
    hs_v = 1'b0; hs_len = '0; hs_w = '0;
    ms_v = 1'b0; ms_len = '0; ms_w = '0;
    for (int w = 0; w < WPC; w++) begin
      if (len[w] != '0) begin
        if (hit[w]) begin
          if (!hs_v || (len[w] < hs_len)) begin
            hs_v = 1'b1; hs_len = len[w]; hs_w = WARP_W'(w);
          end
        end else begin
          if (!ms_v || (len[w] < ms_len)) begin
            ms_v = 1'b1; ms_len = len[w]; ms_w = WARP_W'(w);
          end
        end
      end
    end
  end

  // fixed-point compare: hs << K_FRAC against ms * k
  assign hs_scaled  = PROD_W'(hs_len) << K_FRAC;
  assign ms_scaled  = PROD_W'(ms_len) * PROD_W'(k);
  assign choose_ms  = ms_v && (!hs_v || (hs_scaled > ms_scaled));
  assign pick_valid = hs_v || ms_v;
  assign pick_warp  = choose_ms ? ms_w : hs_w;
  assign pick_hit   = pick_valid && !choose_ms;

endmodule

// File: rtl/shq_bank_sched.sv
// Per-bank warp-aware shortest-queue request scheduler.
module shq_bank_sched #(
  parameter int N_CORES        = 2,
  parameter int WARPS_PER_CORE = 4,
  parameter int CNT_W          = 5,
  parameter int ROW_W          = 8,
  parameter int WCNT_W         = 8,
  parameter int K_W            = 8,
  parameter int K_FRAC         = 4,
  parameter int K_RESET        = 144,
  localparam int CORE_W        = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int WARP_W        = (WARPS_PER_CORE > 1) ? $clog2(WARPS_PER_CORE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enq_valid,
  input  logic [CORE_W-1:0] enq_core,
  input  logic [WARP_W-1:0] enq_warp,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic              enq_write,
  input  logic [ROW_W-1:0]  open_row,
  input  logic              wcnt_load,
  input  logic [CORE_W-1:0] wcnt_core,
  input  logic [WCNT_W-1:0] wcnt_value,
  input  logic              k_load,
  input  logic [K_W-1:0]    k_value,
  input  logic              write_equal,
  input  logic              bank_ready,
  output logic              gnt_valid,
  output logic [CORE_W-1:0] gnt_core,
  output logic [WARP_W-1:0] gnt_warp,
  output logic              gnt_hit,
  output logic              gnt_write
);

  import shq_pkg::*;

  localparam int N_WARPS = N_CORES * WARPS_PER_CORE;
  localparam int WIDX_W  = (N_WARPS > 1) ? $clog2(N_WARPS) : 1;
  localparam int LEN_W   = CNT_W + 1;

  function automatic logic [WIDX_W-1:0] widx(input logic [CORE_W-1:0] c,
                                             input logic [WARP_W-1:0] w);
    return WIDX_W'(int'(c) * WARPS_PER_CORE + int'(w));
  endfunction

  wr_mode_e mode;
  assign mode = wr_mode_e'(write_equal);

  // ---------------- assigned-warp counts and k register ----------------
  logic [N_CORES-1:0][WCNT_W-1:0] wcnt_q, wcnt_d;
  logic [K_W-1:0]                 k_q, k_d;

  always_comb begin
    wcnt_d = wcnt_q;
    if (wcnt_load) wcnt_d[wcnt_core] = wcnt_value;
    k_d = k_load ? k_value : k_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      k_q    <= K_W'(K_RESET);
    end else begin
      wcnt_q <= wcnt_d;
      k_q    <= k_d;
    end
  end

  // ---------------- per-warp counters ----------------
  logic [N_WARPS-1:0][CNT_W-1:0] rd_cnt, wr_cnt;
  logic [N_WARPS-1:0][ROW_W-1:0] row_tag;
  logic [WIDX_W-1:0]             enq_idx, g_idx;

  assign enq_idx = widx(enq_core, enq_warp);

  shq_counters #(
    .N_WARPS(N_WARPS), .CNT_W(CNT_W), .ROW_W(ROW_W), .WIDX_W(WIDX_W)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n),
    .enq_valid(enq_valid), .enq_idx(enq_idx), .enq_row(enq_row), .enq_write(enq_write),
    .dec_valid(gnt_valid), .dec_idx(g_idx), .dec_write(gnt_write),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .row_tag(row_tag)
  );

  // ---------------- queue lengths and hit flags ----------------
  logic                          any_rd;
  logic [N_WARPS-1:0][LEN_W-1:0] len_w;
  logic [N_WARPS-1:0]            hit_w;
  logic [N_CORES-1:0]            core_busy;

  always_comb begin
    any_rd = 1'b0;
    for (int w = 0; w < N_WARPS; w++) any_rd = any_rd || (rd_cnt[w] != '0);
    for (int w = 0; w < N_WARPS; w++) begin
      if (mode == WR_EQUAL)  len_w[w] = LEN_W'(rd_cnt[w]) + LEN_W'(wr_cnt[w]);
      else if (any_rd)       len_w[w] = LEN_W'(rd_cnt[w]);
      else                   len_w[w] = LEN_W'(wr_cnt[w]);
      hit_w[w] = (len_w[w] != '0) && (row_tag[w] == open_row);
    end
    for (int c = 0; c < N_CORES; c++) begin
      core_busy[c] = 1'b0;
      for (int w = 0; w < WARPS_PER_CORE; w++)
        core_busy[c] = core_busy[c] || (len_w[widx(CORE_W'(c), WARP_W'(w))] != '0);
    end
  end

  // ---------------- core then queue selection ----------------
  logic                                  core_any;
  logic [CORE_W-1:0]                     core_sel;
  logic [WARPS_PER_CORE-1:0][LEN_W-1:0]  sel_len;
  logic [WARPS_PER_CORE-1:0]             sel_hit;
  logic                                  pick_valid, pick_hit;
  logic [WARP_W-1:0]                     pick_warp;

  shq_core_pick #(
    .N_CORES(N_CORES), .WCNT_W(WCNT_W), .CORE_W(CORE_W)
  ) u_core (
    .core_busy(core_busy), .wcnt(wcnt_q), .core_any(core_any), .core_sel(core_sel)
  );

  always_comb begin
    for (int w = 0; w < WARPS_PER_CORE; w++) begin
      sel_len[w] = len_w[widx(core_sel, WARP_W'(w))];
      sel_hit[w] = hit_w[widx(core_sel, WARP_W'(w))];
    end
  end

  shq_queue_pick #(
    .WPC(WARPS_PER_CORE), .LEN_W(LEN_W), .K_W(K_W), .K_FRAC(K_FRAC), .WARP_W(WARP_W)
  ) u_queue (
    .len(sel_len), .hit(sel_hit), .k(k_q),
    .pick_valid(pick_valid), .pick_warp(pick_warp), .pick_hit(pick_hit)
  );

  // ---------------- sticky hit queue and grant ----------------
  logic              stk_v_q, stk_v_d;
  logic [CORE_W-1:0] stk_core_q, stk_core_d;
  logic [WARP_W-1:0] stk_warp_q, stk_warp_d;
  logic              stk_ok;

  assign stk_ok = stk_v_q && hit_w[widx(stk_core_q, stk_warp_q)];

  always_comb begin
    gnt_valid = 1'b0;
    gnt_hit   = 1'b0;
    gnt_core  = stk_core_q;
    gnt_warp  = stk_warp_q;
    if (bank_ready) begin
      if (stk_ok) begin
        gnt_valid = 1'b1;
        gnt_hit   = 1'b1;
      end else if (core_any && pick_valid) begin
        gnt_valid = 1'b1;
        gnt_hit   = pick_hit;
        gnt_core  = core_sel;
        gnt_warp  = pick_warp;
      end
    end
    g_idx = widx(gnt_core, gnt_warp);
    if (mode == WR_EQUAL) gnt_write = (rd_cnt[g_idx] == '0);
    else                  gnt_write = !any_rd;
  end

  always_comb begin
    stk_v_d    = stk_v_q;
    stk_core_d = stk_core_q;
    stk_warp_d = stk_warp_q;
    if (gnt_valid) begin
      stk_v_d    = gnt_hit;
      stk_core_d = gnt_core;
      stk_warp_d = gnt_warp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stk_v_q    <= 1'b0;
      stk_core_q <= '0;
      stk_warp_q <= '0;
    end else begin
      stk_v_q    <= stk_v_d;
      stk_core_q <= stk_core_d;
      stk_warp_q <= stk_warp_d;
    end
  end

endmodule

// File: rtl/shq_sched_chk.sv
// Assertion checker for shq_bank_sched, attached with bind below.
module shq_sched_chk #(
  parameter int N_CORES        = 2,
  parameter int WARPS_PER_CORE = 4,
  parameter int CNT_W          = 5,
  parameter int CORE_W         = 1,
  parameter int WARP_W         = 2,
  parameter int WIDX_W         = 3
) (
  input logic                                           clk,
  input logic                                           rst_n,
  input logic                                           bank_ready,
  input logic                                           write_equal,
  input logic                                           gnt_valid,
  input logic [CORE_W-1:0]                              gnt_core,
  input logic [WARP_W-1:0]                              gnt_warp,
  input logic                                           gnt_write,
  input logic                                           enq_valid,
  input logic [CORE_W-1:0]                              enq_core,
  input logic [WARP_W-1:0]                              enq_warp,
  input logic                                           enq_write,
  input logic [N_CORES*WARPS_PER_CORE-1:0][CNT_W-1:0]   rd_cnt,
  input logic [N_CORES*WARPS_PER_CORE-1:0][CNT_W-1:0]   wr_cnt
);

  localparam int N_WARPS = N_CORES * WARPS_PER_CORE;

  logic [WIDX_W-1:0] g_idx, e_idx, chk_idx;
  logic [CNT_W-1:0]  rd_at_g, wr_at_g, chk_val;
  logic              no_reads, same_rd_enq, chk_v;

  always_comb begin
    g_idx   = WIDX_W'(int'(gnt_core) * WARPS_PER_CORE + int'(gnt_warp));
    e_idx   = WIDX_W'(int'(enq_core) * WARPS_PER_CORE + int'(enq_warp));
    rd_at_g = rd_cnt[g_idx];
    wr_at_g = wr_cnt[g_idx];
    no_reads = 1'b1;
    for (int w = 0; w < N_WARPS; w++) if (rd_cnt[w] != '0) no_reads = 1'b0;
    same_rd_enq = enq_valid && !enq_write && (e_idx == g_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_v   <= 1'b0;
      chk_idx <= '0;
      chk_val <= '0;
    end else begin
      chk_v   <= gnt_valid && !gnt_write && !same_rd_enq;
      chk_idx <= g_idx;
      chk_val <= rd_at_g - CNT_W'(1);
    end
  end

  assert_idle_no_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_ready |-> !gnt_valid);

  assert_grant_nonempty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> (gnt_write ? (wr_at_g != '0) : (rd_at_g != '0)));

  assert_read_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_v |-> (rd_cnt[chk_idx] == chk_val));

  assert_defer_writes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !write_equal && gnt_write) |-> no_reads);

  assert_read_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && write_equal && gnt_write) |-> (rd_at_g == '0));

  for (genvar w = 0; w < N_WARPS; w++) begin : g_wrap
    assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_cnt[w] == {CNT_W{1'b1}}) |=> (rd_cnt[w] != '0));
  end

endmodule

bind shq_bank_sched shq_sched_chk #(
  .N_CORES(N_CORES), .WARPS_PER_CORE(WARPS_PER_CORE), .CNT_W(CNT_W),
  .CORE_W(CORE_W), .WARP_W(WARP_W), .WIDX_W(WIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bank_ready(bank_ready), .write_equal(write_equal),
  .gnt_valid(gnt_valid), .gnt_core(gnt_core), .gnt_warp(gnt_warp), .gnt_write(gnt_write),
  .enq_valid(enq_valid), .enq_core(enq_core), .enq_warp(enq_warp), .enq_write(enq_write),
  .rd_cnt(rd_cnt), .wr_cnt(wr_cnt)
);

// File: tb/shq_bank_sched_tb.sv
`timescale 1ns/1ps
module shq_bank_sched_tb;

  localparam int N_CORES = 2;
  localparam int WPC     = 4;
  localparam int ROW_W   = 8;
  localparam int WCNT_W  = 8;
  localparam int K_W     = 8;
  localparam int CORE_W  = 1;
  localparam int WARP_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enq_valid = 1'b0, enq_write = 1'b0;
  logic [CORE_W-1:0] enq_core = '0;
  logic [WARP_W-1:0] enq_warp = '0;
  logic [ROW_W-1:0]  enq_row = '0, open_row = '0;
  logic              wcnt_load = 1'b0, k_load = 1'b0, write_equal = 1'b0, bank_ready = 1'b0;
  logic [CORE_W-1:0] wcnt_core = '0;
  logic [WCNT_W-1:0] wcnt_value = '0;
  logic [K_W-1:0]    k_value = '0;
  logic              gnt_valid, gnt_hit, gnt_write;
  logic [CORE_W-1:0] gnt_core;
  logic [WARP_W-1:0] gnt_warp;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  shq_bank_sched #(
    .N_CORES(N_CORES), .WARPS_PER_CORE(WPC), .CNT_W(5), .ROW_W(ROW_W),
    .WCNT_W(WCNT_W), .K_W(K_W), .K_FRAC(4), .K_RESET(144)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_core(enq_core),
    .enq_warp(enq_warp), .enq_row(enq_row), .enq_write(enq_write), .open_row(open_row),
    .wcnt_load(wcnt_load), .wcnt_core(wcnt_core), .wcnt_value(wcnt_value),
    .k_load(k_load), .k_value(k_value), .write_equal(write_equal),
    .bank_ready(bank_ready), .gnt_valid(gnt_valid), .gnt_core(gnt_core),
    .gnt_warp(gnt_warp), .gnt_hit(gnt_hit), .gnt_write(gnt_write)
  );

  function automatic int pack(int v, int c, int w, int h, int wr);
    return (v << (CORE_W + WARP_W + 2)) | (c << (WARP_W + 2)) | (w << 2) | (h << 1) | wr;
  endfunction

  task automatic expect_eq(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enq_valid = 1'b0; wcnt_load = 1'b0; k_load = 1'b0; bank_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic enq(int c, int w, int row, int wr, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      enq_valid = 1'b1; enq_core = CORE_W'(c); enq_warp = WARP_W'(w);
      enq_row = ROW_W'(row); enq_write = wr[0];
      @(posedge clk); #1;
      enq_valid = 1'b0;
    end
  endtask

  task automatic set_wcnt(int c, int v);
    @(negedge clk);
    wcnt_load = 1'b1; wcnt_core = CORE_W'(c); wcnt_value = WCNT_W'(v);
    @(posedge clk); #1;
    wcnt_load = 1'b0;
  endtask

  task automatic set_k(int v);
    @(negedge clk);
    k_load = 1'b1; k_value = K_W'(v);
    @(posedge clk); #1;
    k_load = 1'b0;
  endtask

  task automatic grant_check(string req, int c, int w, int h, int wr);
    @(negedge clk);
    bank_ready = 1'b1;
    #1;
    expect_eq(req, "grant{v,core,warp,hit,wr}",
              pack(int'(gnt_valid), int'(gnt_core), int'(gnt_warp), int'(gnt_hit), int'(gnt_write)),
              pack(1, c, w, h, wr));
    @(posedge clk); #1;
    bank_ready = 1'b0;
  endtask

  task automatic no_grant_check(string req, logic rdy);
    @(negedge clk);
    bank_ready = rdy;
    #1;
    expect_eq(req, "gnt_valid", int'(gnt_valid), 0);
    @(posedge clk); #1;
    bank_ready = 1'b0;
  endtask

  task automatic drain_check(string req, int exp_n);
    int n = 0;
    @(negedge clk);
    bank_ready = 1'b1;
    for (int i = 0; i < 80; i++) begin
      #1;
      if (!gnt_valid) break;
      n++;
      @(negedge clk);
    end
    bank_ready = 1'b0;
    expect_eq(req, "grants until empty", n, exp_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int kset[4] = '{16, 24, 48, 144};

    // ---------------- R1 / R10: reset state and idle ----------------
    write_equal = 1'b0;
    open_row = 8'd5;
    do_reset();
    no_grant_check("R1 empty after reset", 1'b1);
    enq(0, 2, 5, 0, 1);
    no_grant_check("R1 bank not ready", 1'b0);
    grant_check("R10 same-cycle grant", 0, 2, 1, 0);
    no_grant_check("R10 decrement seen by next grant", 1'b1);

    // ---------------- R5: k comparison sweep ----------------
    foreach (kset[ki]) begin
      for (int h = 1; h <= 5; h++) begin
        for (int m = 1; m <= 5; m++) begin
          bit take_ms;
          do_reset();
          if (kset[ki] != 144) set_k(kset[ki]);
          enq(0, 0, 5, 0, h);
          enq(0, 1, 9, 0, m);
          take_ms = (h * 16) > (kset[ki] * m);
          if (take_ms) grant_check("R5 miss queue wins", 0, 1, 0, 0);
          else         grant_check("R5 hit queue wins", 0, 0, 1, 0);
        end
      end
    end

    // ---------------- R4 / R6: shortest queues and ties ----------------
    do_reset();
    enq(0, 2, 5, 0, 2);
    enq(0, 1, 5, 0, 2);
    enq(0, 3, 9, 0, 1);
    grant_check("R4 hit tie to lower warp", 0, 1, 1, 0);

    do_reset();
    enq(0, 1, 7, 0, 3);
    enq(0, 3, 7, 0, 1);
    enq(0, 2, 7, 0, 1);
    grant_check("R6 only misses, shortest lowest", 0, 2, 0, 0);

    do_reset();
    enq(0, 3, 5, 0, 4);
    enq(0, 0, 5, 0, 6);
    grant_check("R6 only hits, shortest", 0, 3, 1, 0);

    do_reset();
    enq(0, 1, 7, 0, 2);
    enq(0, 1, 5, 0, 1);
    grant_check("R4 row tag follows latest enqueue", 0, 1, 1, 0);

    // ---------------- R2: core selection sweep ----------------
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        do_reset();
        set_wcnt(0, a);
        set_wcnt(1, b);
        enq(0, 0, 5, 0, 1);
        enq(1, 0, 5, 0, 1);
        grant_check("R2 least tolerant core", (b < a) ? 1 : 0, 0, 1, 0);
      end
    end
    do_reset();
    set_wcnt(0, 1);
    set_wcnt(1, 5);
    enq(1, 3, 9, 0, 1);
    grant_check("R2 idle core skipped", 1, 3, 0, 0);

    // ---------------- R7: sticky hit queue ----------------
    do_reset();
    set_wcnt(0, 5);
    enq(0, 0, 5, 0, 3);
    grant_check("R7 first hit", 0, 0, 1, 0);
    enq(1, 0, 5, 0, 1);
    grant_check("R7 sticky over other core", 0, 0, 1, 0);
    grant_check("R7 sticky until drained", 0, 0, 1, 0);
    grant_check("R7 reselect after drain", 1, 0, 1, 0);
    no_grant_check("R7 all drained", 1'b1);

    do_reset();
    enq(0, 0, 5, 0, 3);
    enq(0, 1, 6, 0, 2);
    grant_check("R7 hit before row change", 0, 0, 1, 0);
    open_row = 8'd6;
    grant_check("R7 reselect after row change", 0, 1, 1, 0);
    open_row = 8'd5;

    // ---------------- R3: counting ----------------
    do_reset();
    enq(0, 0, 5, 0, 4);
    enq(1, 2, 8, 0, 3);
    drain_check("R3 grants equal enqueues", 7);

    do_reset();
    enq(0, 1, 5, 0, 2);
    @(negedge clk);
    enq_valid = 1'b1; enq_core = 1'b0; enq_warp = 2'd1; enq_row = 8'd5; enq_write = 1'b0;
    bank_ready = 1'b1;
    #1;
    expect_eq("R3 grant with enqueue", "gnt warp", int'(gnt_warp), 1);
    @(posedge clk); #1;
    enq_valid = 1'b0; bank_ready = 1'b0;
    drain_check("R3 enqueue+grant leaves count", 2);

    // ---------------- R8: writes deferred ----------------
    do_reset();
    enq(0, 0, 5, 1, 1);
    enq(1, 1, 9, 0, 2);
    grant_check("R8 read before hit write", 1, 1, 0, 0);
    grant_check("R8 second read", 1, 1, 0, 0);
    grant_check("R8 write after reads", 0, 0, 1, 1);
    no_grant_check("R8 empty", 1'b1);

    // ---------------- R9: writes equal ----------------
    write_equal = 1'b1;
    do_reset();
    enq(0, 0, 5, 1, 1);
    enq(1, 1, 9, 0, 2);
    grant_check("R9 write counted in queue", 0, 0, 1, 1);
    grant_check("R9 then reads", 1, 1, 0, 0);
    grant_check("R9 then reads again", 1, 1, 0, 0);

    do_reset();
    enq(0, 2, 5, 1, 1);
    enq(0, 2, 5, 0, 1);
    grant_check("R9 read first in warp", 0, 2, 1, 0);
    grant_check("R9 write second in warp", 0, 2, 1, 1);

    do_reset();
    enq(0, 3, 5, 0, 2);
    @(negedge clk);
    enq_valid = 1'b1; enq_core = 1'b0; enq_warp = 2'd3; enq_row = 8'd5; enq_write = 1'b1;
    bank_ready = 1'b1;
    #1;
    expect_eq("R3 R9 grant with write enqueue", "gnt_write", int'(gnt_write), 0);
    @(posedge clk); #1;
    enq_valid = 1'b0; bank_ready = 1'b0;
    drain_check("R9 queue length kept", 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule